// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block turns an asynchronous serial line into bytes. It waits for the line to fall from its idle high level and treats that fall as a possible start bit. It then checks the start bit at its centre. If the start bit holds, the block samples each following bit at its centre, half a bit time after the bit boundary. Timing comes from a counter that runs for a parameterized number of clocks per bit. Data arrives least significant bit first. An optional parity bit can follow the last data bit, and it is checked in either even or odd sense.

The block samples only the first stop bit. A sender may use one, one and a half or two stop bits, and the receiver accepts any of them. Once it has sampled the stop bit, the receiver is ready for the next falling edge. The output byte and its two error flags appear together with a one-clock valid strobe. They stay unchanged until the next frame completes. Start and stop bits are used only to delimit the frame and never appear in the output byte.

Top module: `uart_rx_mid`

## Requirements
- R1: While reset is asserted and right after it, `rx_valid`, `rx_data`, `par_err` and `frm_err` are all zero.
- R2: Each frame delivers a byte in `rx_data`. The first data bit after the start bit becomes bit 0 and the last data bit becomes bit 7. No start or stop level appears in the byte.
- R3: Each accepted frame raises `rx_valid` for exactly one clock.
- R4: A low pulse shorter than half a bit time that is high again at the start bit's centre yields no strobe. A frame sent afterwards is received correctly.
- R5: With `par_en`=1, one parity bit follows the last data bit. With `par_odd`=0, the data bits and parity bit together must hold an even number of ones. With `par_odd`=1, they must hold an odd number. `par_err` is 1 with the strobe exactly when this rule is broken.
- R6: With `par_en`=0, no parity bit is expected. The bit after the last data bit is taken as the stop bit, and `par_err` is 0 with every strobe.
- R7: A stop-bit sample at low level sets `frm_err` to 1 with the strobe, and the byte is still delivered. A high stop-bit sample gives `frm_err`=0.
- R8: A single high stop bit is enough. Frames sent back to back with 1, 1.5 or 2 stop bits are all received.
- R9: Between strobes, `rx_data`, `par_err` and `frm_err` keep the values delivered with the last strobe.
- R10: For frames sent back to back with one stop bit and no parity, strobes are exactly 10 bit times apart. Strobes are never closer than 9 bit times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Raw serial input, idle high |
| par_en | input | 1 | 1: a parity bit follows the data bits |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock strobe marking a new byte |
| par_err | output | 1 | Parity mismatch of the last frame |
| frm_err | output | 1 | Low stop bit in the last frame |

## Verification
The assertions check four things on every cycle:
- the strobe lasts a single clock;
- the byte and flags hold still between strobes;
- the parity flag stays clear whenever parity is off;
- strobes never come closer together than nine bit times.

Bit order, the parity sense, stop-bit tolerance, glitch rejection and the exact ten-bit spacing of back-to-back frames depend on the serial waveform. Only the bench's scenarios can show these:
- a sweep of every byte value in all three parity modes, with varied stop lengths;
- a sweep with corrupted parity;
- bad stop bits;
- a short glitch.

// File: rtl/uart_rx_mid.sv
module uart_rx_mid #(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 par_err,
  output logic                 frm_err
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int BW   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_t;

  state_t               st;
  logic [2:0]           sync_q;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bit_i;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_bit;

  wire line     = sync_q[1];
  wire fall     = sync_q[2] & ~sync_q[1];
  wire at_half  = (cnt == CW'(HALF - 1));
  wire at_full  = (cnt == CW'(CLKS_PER_BIT - 1));
  wire last_bit = (bit_i == BW'(DATA_BITS - 1));
  wire par_bad  = ((^shreg) ^ par_bit) != par_odd;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], rx_line};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bit_i    <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (fall) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (at_half) begin
          cnt   <= '0;
          bit_i <= '0;
          st    <= line ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (at_full) begin
          cnt   <= '0;
          shreg <= {line, shreg[DATA_BITS-1:1]};
          if (last_bit) st <= par_en ? S_PAR : S_STOP;
          else          bit_i <= bit_i + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_PAR: if (at_full) begin
          cnt     <= '0;
          par_bit <= line;
          st      <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (at_full) begin
          cnt      <= '0;
          st       <= S_IDLE;
          rx_valid <= 1'b1;
          rx_data  <= shreg;
          frm_err  <= ~line;
          par_err  <= par_en & par_bad;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_mid_chk.sv
module uart_rx_mid_chk #(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 par_en,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 rx_valid,
  input logic                 par_err,
  input logic                 frm_err
);
  localparam int MIN_GAP = 9 * CLKS_PER_BIT;

  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (rx_valid) begin
      gap  <= 0;
      seen <= 1'b1;
    end else if (gap < MIN_GAP) begin
      gap <= gap + 1;
    end
  end

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R3

  AST_NO_PARITY_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !par_en) |-> !par_err); // R6

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(par_err) && $stable(frm_err))); // R9

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && seen) |-> (gap >= MIN_GAP - 1)); // R10
endmodule

bind uart_rx_mid uart_rx_mid_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT),
  .DATA_BITS(DATA_BITS)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .par_en(par_en),
  .rx_data(rx_data),
  .rx_valid(rx_valid),
  .par_err(par_err),
  .frm_err(frm_err)
);

// File: tb/sim_uart_rx_mid.sv
module sim_uart_rx_mid;
  localparam int CLK_P = 10;
  localparam int CPB   = 8;
  localparam int WD    = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int cyc = 0;
  int last_t = 0;
  bit spacing_on = 1'b0;
  bit have_prev = 1'b0;
  bit prev_valid = 1'b0;
  bit finished = 1'b0;
  logic [10:0] exp_q[$];

  uart_rx_mid #(.CLKS_PER_BIT(CPB), .DATA_BITS(8)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .par_en(par_en),
    .par_odd(par_odd), .rx_data(rx_data), .rx_valid(rx_valid),
    .par_err(par_err), .frm_err(frm_err));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      logic [10:0] e;
      vcount++;
      chk(!prev_valid, "R3", "strobe longer than one clock", 1, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected strobe", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(rx_data == e[7:0], "R2", "data", rx_data, e[7:0]);
        chk(par_err == e[8], e[10] ? "R5" : "R6", "parity flag", par_err, e[8]);
        chk(frm_err == e[9], "R7", "framing flag", frm_err, e[9]);
      end
      if (spacing_on && have_prev)
        chk(cyc - last_t == 10 * CPB, "R10", "strobe spacing", cyc - last_t, 10 * CPB);
      have_prev = 1'b1;
      last_t = cyc;
    end
    prev_valid = rx_valid;
  end

  task automatic drive_bit(input logic v, input int clocks);
    rx_line = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit pen, input bit podd,
                      input bit bad_par, input bit bad_stop, input int stop_halves);
    logic pbit;
    par_en  = pen;
    par_odd = podd;
    pbit = (^d) ^ podd ^ bad_par;
    exp_q.push_back({pen, bad_stop, pen & bad_par, d});
    drive_bit(1'b0, CPB);
    for (int i = 0; i < 8; i++) drive_bit(d[i], CPB);
    if (pen) drive_bit(pbit, CPB);
    drive_bit(~bad_stop, stop_halves * CPB / 2);
    if (bad_stop) drive_bit(1'b1, 2 * CPB);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", cyc, WD);
    summary();
  end

  initial begin
    int sent;
    repeat (4) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_data == 8'h00 && par_err == 1'b0 && frm_err == 1'b0,
        "R1", "outputs in reset", {rx_valid, par_err, frm_err, rx_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_data == 8'h00 && par_err == 1'b0 && frm_err == 1'b0,
        "R1", "outputs after reset", {rx_valid, par_err, frm_err, rx_data}, 0);

    sent = 0;
    for (int m = 0; m < 3; m++)
      for (int d = 0; d < 256; d++) begin
        send(8'(d), m != 0, m == 2, 1'b0, 1'b0, 2 + (d % 3));
        sent++;
      end
    for (int d = 0; d < 256; d++) begin
      send(8'(d), 1'b1, d[0], 1'b1, 1'b0, 2 + (d % 3));
      sent++;
    end
    drive_bit(1'b1, 2 * CPB);
    chk(vcount == sent, "R8", "frames with 1/1.5/2 stop bits delivered", vcount, sent);

    for (int k = 0; k < 8; k++) begin
      send(8'(8'h3C ^ (k * 37)), k[0], k[1], 1'b0, 1'b1, 2);
      sent++;
    end

    drive_bit(1'b0, 3);
    drive_bit(1'b1, 3 * CPB);
    chk(vcount == sent, "R4", "glitch produced no strobe", vcount, sent);
    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 2);
    sent++;
    drive_bit(1'b1, 2 * CPB);
    chk(vcount == sent, "R4", "frame after glitch received", vcount, sent);

    spacing_on = 1'b1;
    have_prev = 1'b0;
    for (int k = 0; k < 6; k++) begin
      send(8'(8'h81 + k * 19), 1'b0, 1'b0, 1'b0, 1'b0, 2);
      sent++;
    end
    drive_bit(1'b1, 5 * CPB);
    spacing_on = 1'b0;
    chk(vcount == sent, "R10", "back-to-back frames all received", vcount, sent);
    chk(rx_data == 8'(8'h81 + 5 * 19) && !par_err && !frm_err, "R9",
        "outputs held after idle", {par_err, frm_err, rx_data}, 8'(8'h81 + 5 * 19));

    send(8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 2);
    sent++;
    drive_bit(1'b1, 6 * CPB);
    chk(rx_data == 8'h5A && par_err && frm_err, "R9", "error flags held",
        {par_err, frm_err, rx_data}, {2'b11, 8'h5A});
    chk(exp_q.size() == 0, "R3", "every frame gave one strobe", exp_q.size(), 0);
    summary();
  end
endmodule